// File: doc/BRIEF.md
# Refreshable Watchdog Timer

A register-mapped watchdog that software arms and must keep refreshing. Software programs an 8-bit reload value and then sets the enable bit in the control word. From that moment a countdown of (reload + 1) ticks begins. Each tick lasts a fixed 20 ms, taken from a prescaler that divides the system clock. Each refresh restarts the full countdown. A refresh is a control write that keeps the enable bit set and also sets the trigger bit.

If the countdown reaches zero while the watchdog is armed, the block raises a sticky expiry flag and drives `timeout_o`. Both stay set until software disarms the watchdog by writing the control word with the enable bit clear, or until reset. Software reads the reload value, the enable bit and the expiry flag through a combinational read port.

Top module: `wdt_periph`

## Requirements
- R1: After reset the enable is 0, the reload value is 0, `timeout_o` is 0, and a status read at 0x20 returns 0.
- R2: A write to 0x14 stores `wr_data[7:0]` as the reload value. A read at 0x14 returns that value with bits 31:8 zero, and the upper write bits are ignored.
- R3: In the control word at 0x1C, bit 0 is the enable. A read at 0x1C returns the enable in bit 0 and always returns bit 9 (the refresh trigger) as 0. In the status word at 0x20, bit 0 mirrors the enable and bit 1 is the expiry flag.
- R4: A control write with bit 0 set to a disabled watchdog arms it. `timeout_o` and status bit 1 rise exactly (reload + 1) × CYC_PER_TICK clock edges after the edge that took the write, where CYC_PER_TICK = CLK_FREQ_HZ / 1e6 × TICK_US. The default is 20 ms.
- R5: A control write with bits 0 and 9 set while armed and not expired restarts the full (reload + 1)-tick window from the edge that took the write.
- R6: A control write with bit 0 set and bit 9 clear while already armed leaves the running countdown unchanged.
- R7: A control write with bit 9 set and bit 0 clear while disabled has no effect: the watchdog stays disabled and never times out.
- R8: Expiry is sticky. Once set, `timeout_o` and status bit 1 remain 1, including across refresh writes.
- R9: A control write with bit 0 clear disarms the watchdog and clears the enable, the expiry flag and `timeout_o` from the next clock.
- R10: A reload write made while armed does not change the running countdown. The new value applies from the next arm or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Combinational read data |
| timeout_o | output | 1 | Watchdog expired (sticky) |

## Verification
A wrong tick count or a lost reload shows up only at the single edge where `timeout_o` rises. The bench therefore checks the cycle just before the expected expiry and the cycle of the expiry, across a sweep of reload values. If refresh decoding is corrupt, the expiry lands at the edge the original arm predicted rather than at the edge the refresh predicted, so the error shows within one window. If the sticky flag or the disarm is corrupt, the status word or `timeout_o` is wrong on the very next cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int RELOAD_W  = 8;
    localparam int CNT_W     = RELOAD_W + 1;
    localparam int OFS_RELOAD = 'h14;
    localparam int OFS_CTRL   = 'h1C;
    localparam int OFS_STATUS = 'h20;
    localparam int BIT_ENABLE = 0;
    localparam int BIT_TRIG   = 9;
    localparam int BIT_EXPIRE = 1;

    typedef struct packed {
        logic                en;
        logic [RELOAD_W-1:0] reload;
    } wdt_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             expired;
    } wdt_cnt_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int CYC_PER_TICK = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_TICK - 1);

    logic [PW-1:0] presc_d, presc_q;

    always_comb begin
        tick    = run && !restart && (presc_q == LAST);
        presc_d = presc_q;
        if (restart || !run)
            presc_d = '0;
        else if (presc_q == LAST)
            presc_d = '0;
        else
            presc_d = presc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic                clear,
    input  logic                tick,
    output logic [CNT_W-1:0]    count,
    output logic                expired
);
    wdt_cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.count   = '0;
            st_d.expired = 1'b0;
        end else if (load) begin
            st_d.count   = CNT_W'(load_val) + 1'b1;
            st_d.expired = 1'b0;
        end else if (tick && st_q.count != '0) begin
            st_d.count = st_q.count - 1'b1;
            if (st_q.count == CNT_W'(1))
                st_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign expired = st_q.expired;
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph
    import wdt_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int TICK_US     = 20_000,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_o
);
    localparam int CYC_PER_TICK = (CLK_FREQ_HZ / 1_000_000) * TICK_US;

    wdt_regs_t        regs_d, regs_q;
    logic             ctrl_wr, reload_wr;
    logic             restart, disarm, run, tick, expired;
    logic [CNT_W-1:0] cnt_val;
    logic             en_w;

    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
        reload_wr = wr_en && (wr_addr == ADDR_W'(OFS_RELOAD));
        disarm    = ctrl_wr && !wr_data[BIT_ENABLE];
        // arm from disabled, or refresh while armed and not yet expired
        restart   = ctrl_wr && wr_data[BIT_ENABLE] &&
                    (!regs_q.en || (wr_data[BIT_TRIG] && !expired));
        run       = regs_q.en && !expired && !disarm;

        regs_d = regs_q;
        if (ctrl_wr)
            regs_d.en = wr_data[BIT_ENABLE];
        if (reload_wr)
            regs_d.reload = wr_data[RELOAD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    wdt_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    wdt_down_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .load_val (regs_q.reload),
        .clear    (disarm),
        .tick     (tick),
        .count    (cnt_val),
        .expired  (expired)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_RELOAD))
            rd_data[RELOAD_W-1:0] = regs_q.reload;
        else if (rd_addr == ADDR_W'(OFS_CTRL))
            rd_data[BIT_ENABLE] = regs_q.en;
        else if (rd_addr == ADDR_W'(OFS_STATUS)) begin
            rd_data[BIT_ENABLE] = regs_q.en;
            rd_data[BIT_EXPIRE] = expired;
        end
    end

    assign en_w      = regs_q.en;
    assign timeout_o = expired;
endmodule

// File: rtl/wdt_periph_chk.sv
module wdt_periph_chk
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              timeout_o,
    input logic              en,
    input logic              restart,
    input logic [CNT_W-1:0]  count
);
    logic ctrl_off;
    assign ctrl_off = wr_en && (wr_addr == ADDR_W'(OFS_CTRL)) && !wr_data[BIT_ENABLE];

    assert_sticky_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !ctrl_off) |=> timeout_o);

    assert_disarm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> (!en && !timeout_o));

    assert_timeout_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> en);

    assert_count_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (count <= $past(count)));

    assert_expire_at_last_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> ($past(count) == CNT_W'(1)));
endmodule

bind wdt_periph wdt_periph_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .timeout_o (timeout_o),
    .en        (en_w),
    .restart   (restart),
    .count     (cnt_val)
);

// File: tb/wdt_periph_tb.sv
module wdt_periph_tb;
    localparam int CYC = 3;
    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic        timeout_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt_periph #(.CLK_FREQ_HZ(1_000_000), .TICK_US(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .timeout_o(timeout_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a negedge; returns at the negedge after the taking edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // wait until edge (total-1) after taking edge, expect 0, then 1 at edge total
    task automatic expect_expiry(input string req, input int remain);
        logic [31:0] s;
        if (remain > 1) cyc(remain - 1);
        chk(req, {31'd0, timeout_o}, 32'd0);
        cyc(1);
        chk(req, {31'd0, timeout_o}, 32'd1);
        rd('h20, s);
        chk(req, s, 32'h3);
    endtask

    initial begin
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, timeout_o}, 0);
        rd('h20, v); chk("R1", v, 0);
        rd('h14, v); chk("R1", v, 0);
        rd('h1C, v); chk("R1", v, 0);
        // R2 reload storage
        wr('h14, 32'hFFFF_FFA5);
        rd('h14, v); chk("R2", v, 32'hA5);
        // R7 refresh while disabled
        wr('h1C, 32'h200);
        cyc(50);
        chk("R7", {31'd0, timeout_o}, 0);
        rd('h20, v); chk("R7", v, 0);
        // R4 sweep of reload values
        for (int r = 0; r < 40; r++) begin
            int rv;
            rv = (r < 32) ? r : (r == 32 ? 255 : 100 + r);
            wr('h14, rv);
            wr('h1C, 32'h1);
            rd('h1C, v); chk("R3", v, 32'h1);
            expect_expiry("R4", (rv + 1) * CYC);
            wr('h1C, 32'h0);
            chk("R9", {31'd0, timeout_o}, 0);
            rd('h20, v); chk("R9", v, 0);
        end
        // R5 refresh restarts window
        wr('h14, 4);
        wr('h1C, 32'h1);
        cyc(10);
        wr('h1C, 32'h201);
        rd('h1C, v); chk("R3", v, 32'h1);
        expect_expiry("R5", 5 * CYC);
        // R8 sticky across refresh
        wr('h1C, 32'h201);
        cyc(20);
        chk("R8", {31'd0, timeout_o}, 1);
        rd('h20, v); chk("R8", v, 32'h3);
        wr('h1C, 32'h0);
        // R6 enable rewrite without trigger does not restart
        wr('h1C, 32'h1);
        cyc(5);
        wr('h1C, 32'h1);
        expect_expiry("R6", 15 - 6);
        wr('h1C, 32'h0);
        // R10 reload change applies on next refresh only
        wr('h1C, 32'h1);
        wr('h14, 1);
        expect_expiry("R10", 15 - 1);
        wr('h1C, 32'h0);
        wr('h1C, 32'h1);
        cyc(2);
        wr('h14, 9);
        wr('h1C, 32'h201);
        expect_expiry("R10", 10 * CYC);
        wr('h1C, 32'h0);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 150_000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule